// File: doc/BRIEF.md
# Operand-tracking computation unit controller

This controller sits in front of one execution unit and follows a single operation from the moment it is issued until its result has been written back. An issue strobe captures an operation word. The word holds an opcode, an invert-first-input flag, an immediate value, an immediate-valid flag and a zero-first-operand flag. From the next cycle on, the controller reports busy and cannot take another operation.

Each of the two source operands has its own request/grant handshake, and the two handshakes need not run in any fixed order. Operands that come from the immediate, from the forced zero, or from a per-operand read mask never raise a request. The controller sends the operand pair to the execution unit over a valid/ready interface only once every required operand has been captured. It then waits for the execution unit's result and keeps it in a register. A write request is raised and held until the write grant arrives. Busy drops in the next cycle, so a result that has been started is never lost.

Top module: `cu_opnd_tracker`

## Requirements
- R1: `busy_o` is low in the cycle where `issue_i` is first sampled high and rises in the following cycle. When the unit is idle and `issue_i` stays low, `busy_o` stays low.
- R2: The operation fields (`opc_i`, `inv_i`, `imm_i`, `imm_vld_i`, `zero_a_i`) are captured in the issue cycle. Changing them on any later cycle has no effect on the operands or on the result.
- R3: `rd_req_o[0]` (operand A) and `rd_req_o[1]` (operand B) rise in the cycle after issue for every operand that must be read. A request does not rise at any other time and stays high until that operand's `rd_go_i` bit is sampled high.
- R4: An operand's data is captured only in the cycle where its `rd_go_i` bit is high. `rd_go_i` may be driven in the very first cycle the request is visible. The request drops in the next cycle. The two operands may be granted in either order or in the same cycle.
- R5: When `zero_a_i` is set, no request is raised for operand A and zero is used in its place. When `imm_vld_i` is set, no request is raised for operand B and `imm_i` is used in its place.
- R6: When `rdmask_i[0]` or `rdmask_i[1]` is high at issue, it suppresses that operand's request completely. `rdmask_i` is held while busy. A masked operand with no other source is given the value zero.
- R7: `eu_valid_o` rises only after every required operand has been captured, with no read request pending. While `eu_ready_i` is low, `eu_valid_o`, `eu_a_o` and `eu_b_o` stay stable.
- R8: `eu_rready_o` is high only while the controller waits for the result. The result is kept in a register and appears on `wr_data_o`. `wr_req_o` is held until `wr_go_i`, and `busy_o` drops in the cycle after the grant.
- R9: An operation that reads no operand completes and releases `busy_o` within 50 cycles of issue, given an execution unit that accepts and answers at once and an immediate write grant.
- R10: A synchronous active-high `rst_i` clears busy and all read and write requests, including in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for a new operation |
| opc_i | input | OPW | Opcode |
| inv_i | input | 1 | Invert-first-input flag, passed to the execution unit |
| imm_i | input | DW | Immediate value |
| imm_vld_i | input | 1 | Use the immediate as operand B |
| zero_a_i | input | 1 | Use zero as operand A |
| rdmask_i | input | 2 | Per-operand read suppression, bit 0 = A, bit 1 = B |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | 2 | Read requests, bit 0 = A, bit 1 = B |
| rd_go_i | input | 2 | Read grants, bit 0 = A, bit 1 = B |
| src_a_i | input | DW | Operand A data, valid in its grant cycle |
| src_b_i | input | DW | Operand B data, valid in its grant cycle |
| eu_valid_o | output | 1 | Operands valid toward the execution unit |
| eu_ready_i | input | 1 | Execution unit accepts the operands |
| eu_opc_o | output | OPW | Captured opcode |
| eu_inv_o | output | 1 | Captured invert flag |
| eu_a_o | output | DW | Operand A toward the execution unit |
| eu_b_o | output | DW | Operand B toward the execution unit |
| eu_rvalid_i | input | 1 | Result valid from the execution unit |
| eu_rdata_i | input | DW | Result data from the execution unit |
| eu_rready_o | output | 1 | Controller ready to take the result |
| wr_req_o | output | 1 | Write request for the result |
| wr_go_i | input | 1 | One-cycle write grant |
| wr_data_o | output | DW | Result held for writeback |

## Verification
The assertions take three things for granted about the inputs:
- `issue_i` is pulsed only while the unit is idle.
- `rdmask_i` stays steady for the whole busy period.
- A grant bit is raised only while its request is visible.

The bench keeps to these rules. Each operation is driven by one task that raises issue for exactly one cycle after checking that the unit is idle, holds the mask until busy falls, and pulses grants only after the request has been seen. After the issue cycle, the task fills the operation fields with random values, so any later sampling of them would corrupt the expected result.

// File: rtl/cu_trk_pkg.sv
package cu_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATHER = 3'd1,
    ST_SEND   = 3'd2,
    ST_RESULT = 3'd3,
    ST_WRITE  = 3'd4
  } cu_state_e;

  // An operand is read from the register file only if it is neither
  // substituted (zero / immediate) nor masked off.
  function automatic logic needs_read(input logic substituted, input logic masked);
    return !(substituted || masked);
  endfunction

endpackage

// File: rtl/cu_src_port.sv
module cu_src_port #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic          need_i,
  input  logic [DW-1:0] preset_i,
  input  logic          go_i,
  input  logic [DW-1:0] data_i,
  output logic          req_o,
  output logic          have_o,
  output logic [DW-1:0] val_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      req_o  <= 1'b0;
      have_o <= 1'b0;
      val_o  <= '0;
    end else if (start_i) begin
      req_o  <= need_i;
      have_o <= !need_i;
      val_o  <= preset_i;
    end else if (req_o && go_i) begin
      req_o  <= 1'b0;
      have_o <= 1'b1;
      val_o  <= data_i;
    end
  end

endmodule

// File: rtl/cu_res_reg.sv
module cu_res_reg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i)      data_o <= '0;
    else if (cap_i) data_o <= data_i;
  end

endmodule

// File: rtl/cu_opnd_tracker.sv
module cu_opnd_tracker
  import cu_trk_pkg::*;
#(
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           issue_i,
  input  logic [OPW-1:0] opc_i,
  input  logic           inv_i,
  input  logic [DW-1:0]  imm_i,
  input  logic           imm_vld_i,
  input  logic           zero_a_i,
  input  logic [1:0]     rdmask_i,
  output logic           busy_o,
  output logic [1:0]     rd_req_o,
  input  logic [1:0]     rd_go_i,
  input  logic [DW-1:0]  src_a_i,
  input  logic [DW-1:0]  src_b_i,
  output logic           eu_valid_o,
  input  logic           eu_ready_i,
  output logic [OPW-1:0] eu_opc_o,
  output logic           eu_inv_o,
  output logic [DW-1:0]  eu_a_o,
  output logic [DW-1:0]  eu_b_o,
  input  logic           eu_rvalid_i,
  input  logic [DW-1:0]  eu_rdata_i,
  output logic           eu_rready_o,
  output logic           wr_req_o,
  input  logic           wr_go_i,
  output logic [DW-1:0]  wr_data_o
);

  localparam int NSRC = 2;

  cu_state_e state_q, state_d;

  // Named internal events
  logic issue_take;
  logic all_have;
  logic send_fire;
  logic res_fire;
  logic wr_fire;

  logic [NSRC-1:0]         subst;
  logic [NSRC-1:0]         need;
  logic [NSRC-1:0]         have;
  logic [NSRC-1:0][DW-1:0] preset;
  logic [NSRC-1:0][DW-1:0] src_pk;
  logic [NSRC-1:0][DW-1:0] val;

  logic [OPW-1:0] opc_q;
  logic           inv_q;

  assign issue_take = issue_i && (state_q == ST_IDLE);
  assign all_have   = &have;
  assign send_fire  = (state_q == ST_SEND) && eu_ready_i;
  assign res_fire   = (state_q == ST_RESULT) && eu_rvalid_i;
  assign wr_fire    = (state_q == ST_WRITE) && wr_go_i;

  assign subst     = {imm_vld_i, zero_a_i};
  assign preset[0] = '0;
  assign preset[1] = imm_vld_i ? imm_i : '0;
  assign src_pk    = {src_b_i, src_a_i};

  for (genvar gk = 0; gk < NSRC; gk++) begin : g_src
    assign need[gk] = needs_read(subst[gk], rdmask_i[gk]);

    cu_src_port #(.DW(DW)) u_port (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .start_i  (issue_take),
      .need_i   (need[gk]),
      .preset_i (preset[gk]),
      .go_i     (rd_go_i[gk]),
      .data_i   (src_pk[gk]),
      .req_o    (rd_req_o[gk]),
      .have_o   (have[gk]),
      .val_o    (val[gk])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (issue_take) state_d = ST_GATHER;
      ST_GATHER: if (all_have)   state_d = ST_SEND;
      ST_SEND:   if (send_fire)  state_d = ST_RESULT;
      ST_RESULT: if (res_fire)   state_d = ST_WRITE;
      ST_WRITE:  if (wr_fire)    state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= ST_IDLE;
    else       state_q <= state_d;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      opc_q <= '0;
      inv_q <= 1'b0;
    end else if (issue_take) begin
      opc_q <= opc_i;
      inv_q <= inv_i;
    end
  end

  cu_res_reg #(.DW(DW)) u_res (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cap_i  (res_fire),
    .data_i (eu_rdata_i),
    .data_o (wr_data_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign eu_valid_o  = (state_q == ST_SEND);
  assign eu_rready_o = (state_q == ST_RESULT);
  assign wr_req_o    = (state_q == ST_WRITE);
  assign eu_opc_o    = opc_q;
  assign eu_inv_o    = inv_q;
  assign eu_a_o      = val[0];
  assign eu_b_o      = val[1];

endmodule

// File: rtl/cu_trk_chk.sv
module cu_trk_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          issue_i,
  input logic          issue_take,
  input logic          zero_a_i,
  input logic          imm_vld_i,
  input logic [1:0]    rdmask_i,
  input logic          busy_o,
  input logic [1:0]    rd_req_o,
  input logic [1:0]    rd_go_i,
  input logic          eu_valid_o,
  input logic          eu_ready_i,
  input logic [DW-1:0] eu_a_o,
  input logic [DW-1:0] eu_b_o,
  input logic          eu_rready_o,
  input logic          wr_req_o,
  input logic          wr_go_i
);

  p_busy_rise_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_take |=> busy_o);
  p_busy_cause_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o && !issue_i |=> !busy_o);

  p_req_origin_a_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rd_req_o[0]) |-> $past(issue_take));
  p_req_origin_b_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rd_req_o[1]) |-> $past(issue_take));
  p_req_hold_a_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_req_o[0] && !rd_go_i[0] |=> rd_req_o[0]);
  p_req_hold_b_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_req_o[1] && !rd_go_i[1] |=> rd_req_o[1]);
  p_req_busy_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_req_o != 2'b00) |-> busy_o);

  p_req_drop_a_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_req_o[0] && rd_go_i[0] |=> !rd_req_o[0]);
  p_req_drop_b_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_req_o[1] && rd_go_i[1] |=> !rd_req_o[1]);

  p_zero_skip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_take && zero_a_i |=> !rd_req_o[0]);
  p_imm_skip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_take && imm_vld_i |=> !rd_req_o[1]);

  p_mask_a_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_take && rdmask_i[0] |=> !rd_req_o[0]);
  p_mask_b_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_take && rdmask_i[1] |=> !rd_req_o[1]);

  p_send_after_reads_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    eu_valid_o |-> (rd_req_o == 2'b00));
  p_send_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    eu_valid_o && !eu_ready_i |=> eu_valid_o && $stable(eu_a_o) && $stable(eu_b_o));

  p_rready_window_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    eu_rready_o |-> !wr_req_o && !eu_valid_o && busy_o);
  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_req_o && !wr_go_i |=> wr_req_o && busy_o);
  p_wr_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_req_o && wr_go_i |=> !busy_o);

endmodule

bind cu_opnd_tracker cu_trk_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .issue_i     (issue_i),
  .issue_take  (issue_take),
  .zero_a_i    (zero_a_i),
  .imm_vld_i   (imm_vld_i),
  .rdmask_i    (rdmask_i),
  .busy_o      (busy_o),
  .rd_req_o    (rd_req_o),
  .rd_go_i     (rd_go_i),
  .eu_valid_o  (eu_valid_o),
  .eu_ready_i  (eu_ready_i),
  .eu_a_o      (eu_a_o),
  .eu_b_o      (eu_b_o),
  .eu_rready_o (eu_rready_o),
  .wr_req_o    (wr_req_o),
  .wr_go_i     (wr_go_i)
);

// File: tb/tb_cu_opnd_tracker.sv
module tb_cu_opnd_tracker;
  localparam int DW  = 16;
  localparam int OPW = 4;

  logic clk = 1'b0;
  logic rst;
  logic issue, inv, imm_vld, zero_a;
  logic [OPW-1:0] opc;
  logic [DW-1:0]  imm, src_a, src_b;
  logic [1:0] rdmask, rd_go;
  logic busy, eu_valid, eu_ready, eu_inv, eu_rvalid, eu_rready, wr_req, wr_go;
  logic [1:0] rd_req;
  logic [OPW-1:0] eu_opc;
  logic [DW-1:0] eu_a, eu_b, eu_rdata, wr_data;

  always #2 clk = ~clk;

  cu_opnd_tracker #(.DW(DW), .OPW(OPW)) dut (
    .clk_i(clk), .rst_i(rst), .issue_i(issue), .opc_i(opc), .inv_i(inv),
    .imm_i(imm), .imm_vld_i(imm_vld), .zero_a_i(zero_a), .rdmask_i(rdmask),
    .busy_o(busy), .rd_req_o(rd_req), .rd_go_i(rd_go), .src_a_i(src_a),
    .src_b_i(src_b), .eu_valid_o(eu_valid), .eu_ready_i(eu_ready),
    .eu_opc_o(eu_opc), .eu_inv_o(eu_inv), .eu_a_o(eu_a), .eu_b_o(eu_b),
    .eu_rvalid_i(eu_rvalid), .eu_rdata_i(eu_rdata), .eu_rready_o(eu_rready),
    .wr_req_o(wr_req), .wr_go_i(wr_go), .wr_data_o(wr_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int eu_acc_dly = 0;
  int eu_lat = 0;
  int rel_cycles = 0;
  bit eu_seen = 0;
  logic [DW-1:0] seen_a, seen_b;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench view of the execution unit's arithmetic (encoding chosen by the bench).
  function automatic logic [DW-1:0] ref_alu(input logic [OPW-1:0] op, input logic iv,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] x;
    x = iv ? ~a : a;
    case (op)
      4'd0:    return x + b;
      4'd1:    return x - b;
      4'd2:    return x & b;
      default: return x ^ b;
    endcase
  endfunction

  // Execution-unit model: accepts after eu_acc_dly cycles, answers after eu_lat.
  initial begin
    eu_ready = 1'b0; eu_rvalid = 1'b0; eu_rdata = '0;
    forever begin
      @(negedge clk);
      if (eu_valid && !rst) begin
        repeat (eu_acc_dly) @(negedge clk);
        eu_ready = 1'b1;
        seen_a = eu_a; seen_b = eu_b; eu_seen = 1'b1;
        eu_rdata = ref_alu(eu_opc, eu_inv, eu_a, eu_b);
        @(negedge clk);
        eu_ready = 1'b0;
        repeat (eu_lat) @(negedge clk);
        eu_rvalid = 1'b1;
        @(negedge clk);
        eu_rvalid = 1'b0;
        eu_rdata = DW'($urandom);
      end
    end
  end

  task automatic producer(input int k, input bit need, input logic [DW-1:0] v, input int d);
    bit bad = 0;
    if (!need) begin
      while (busy) begin
        if (rd_req[k]) bad = 1;
        @(negedge clk);
      end
      chk(!bad, (k == 0) ? "R5/R6 no request A" : "R5/R6 no request B", 32'(bad), 0);
    end else begin
      for (int i = 0; i < d; i++) begin
        chk(rd_req[k], "R3 request held before grant", 32'(rd_req[k]), 1);
        @(negedge clk);
      end
      chk(rd_req[k], "R3 request present at grant", 32'(rd_req[k]), 1);
      rd_go[k] = 1'b1;
      if (k == 0) src_a = v; else src_b = v;
      @(negedge clk);
      rd_go[k] = 1'b0;
      if (k == 0) src_a = DW'($urandom); else src_b = DW'($urandom);
      chk(!rd_req[k], "R4 request drops after grant", 32'(rd_req[k]), 0);
    end
  endtask

  task automatic consumer(input logic [DW-1:0] er, input int dw, input string tag);
    while (!wr_req) begin
      @(negedge clk);
      rel_cycles++;
    end
    for (int i = 0; i < dw; i++) begin
      chk(wr_req && busy, "R8 write request held", 32'(wr_req), 1);
      @(negedge clk);
      rel_cycles++;
    end
    chk(wr_data == er, tag, 32'(wr_data), 32'(er));
    wr_go = 1'b1;
    @(negedge clk);
    rel_cycles++;
    wr_go = 1'b0;
    chk(!busy && !wr_req, "R8 busy drops after write grant", 32'(busy), 0);
  endtask

  task automatic run_op(input logic [OPW-1:0] op, input bit iv, input logic [DW-1:0] im,
                        input bit imv, input bit za, input logic [1:0] mk,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input int da, input int db, input int dw, input string tag);
    bit need0, need1;
    logic [DW-1:0] ea, eb, er;
    need0 = !(za || mk[0]);
    need1 = !(imv || mk[1]);
    ea = need0 ? a : '0;
    eb = imv ? im : (need1 ? b : '0);
    er = ref_alu(op, iv, ea, eb);
    @(negedge clk);
    chk(!busy, "R1 idle before issue", 32'(busy), 0);
    issue = 1'b1; opc = op; inv = iv; imm = im; imm_vld = imv; zero_a = za; rdmask = mk;
    eu_seen = 1'b0;
    @(negedge clk);
    rel_cycles = 1;
    chk(busy, "R1 busy after issue", 32'(busy), 1);
    chk(rd_req[0] == need0, za ? "R5 zero A request" : (mk[0] ? "R6 mask A request" : "R3 request A"),
        32'(rd_req[0]), 32'(need0));
    chk(rd_req[1] == need1, imv ? "R5 imm B request" : (mk[1] ? "R6 mask B request" : "R3 request B"),
        32'(rd_req[1]), 32'(need1));
    issue = 1'b0;
    // R2: scramble the operation fields after the issue cycle
    opc = OPW'($urandom); inv = 1'($urandom); imm = DW'($urandom);
    imm_vld = 1'($urandom); zero_a = 1'($urandom);
    fork
      producer(0, need0, a, da);
      producer(1, need1, b, db);
      consumer(er, dw, tag);
    join
    chk(eu_seen && seen_a == ea, "R7 operand A at execution unit", 32'(seen_a), 32'(ea));
    chk(eu_seen && seen_b == eb, "R7 operand B at execution unit", 32'(seen_b), 32'(eb));
    rdmask = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1'b1; issue = 0; opc = 0; inv = 0; imm = 0; imm_vld = 0; zero_a = 0;
    rdmask = 0; rd_go = 0; src_a = 16'hdead; src_b = 16'hbeef; wr_go = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && rd_req == 2'b00 && !wr_req && !eu_valid, "R10 reset state", 32'(busy), 0);

    // Directed cases
    run_op(4'd0, 0, 16'h0, 0, 0, 2'b00, 16'd13, 16'd2, 0, 2, 0, "R4 A first");
    run_op(4'd1, 0, 16'h0, 0, 0, 2'b00, 16'd300, 16'd45, 2, 0, 2, "R4 B first");
    run_op(4'd3, 0, 16'h0, 0, 0, 2'b00, 16'h5a5a, 16'h0ff0, 1, 1, 1, "R4 same cycle");
    eu_acc_dly = 0; eu_lat = 0;
    run_op(4'd0, 0, 16'd8, 1, 1, 2'b00, 16'd5, 16'd2, 0, 0, 0, "R5 zero and immediate");
    chk(rel_cycles <= 50, "R9 no-read operation bound", 32'(rel_cycles), 50);
    run_op(4'd0, 0, 16'd8, 1, 0, 2'b00, 16'd5, 16'd2, 2, 0, 2, "R5 immediate B");
    run_op(4'd0, 1, 16'd0, 0, 0, 2'b00, 16'd5, 16'd2, 1, 2, 0, "R2 invert A");
    run_op(4'd0, 0, 16'd0, 0, 0, 2'b11, 16'd5, 16'd2, 0, 0, 1, "R6 both masked");
    chk(rel_cycles <= 50, "R9 masked operation bound", 32'(rel_cycles), 50);
    run_op(4'd3, 0, 16'd0, 0, 0, 2'b01, 16'h1234, 16'h00ff, 0, 3, 0, "R6 A masked");

    // Constrained random operations
    for (int n = 0; n < 40; n++) begin
      eu_acc_dly = int'($urandom_range(0, 3));
      eu_lat     = int'($urandom_range(0, 3));
      run_op(OPW'($urandom_range(0, 3)), 1'($urandom), DW'($urandom),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b00,
             DW'($urandom), DW'($urandom),
             int'($urandom_range(0, 4)), int'($urandom_range(0, 4)),
             int'($urandom_range(0, 3)), "R2 random result");
    end

    // Reset in the middle of an operation
    @(negedge clk);
    issue = 1'b1; imm_vld = 0; zero_a = 0; rdmask = 2'b00;
    @(negedge clk);
    issue = 1'b0;
    chk(rd_req == 2'b11, "R3 requests before reset", 32'(rd_req), 3);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && rd_req == 2'b00 && !wr_req, "R10 reset mid operation", 32'({busy, rd_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1 no busy without issue", 32'(busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule